// File: doc/BRIEF.md
# Register Load/Store Transfer Unit

This unit carries out one two-word load or store between a small internal byte-addressed register file and an external memory or I/O location. A single transfer moves one to four bytes. The unit latches both instruction words on `start` and decodes the first word for direction, byte count, address space, relative addressing and register address. It forms the effective address from the second word, either directly or by adding it to a data-structure base. It then checks that the transfer is legal and issues one request on a simple valid/ready bus. A separate acknowledge completes the request and carries read data back.

The byte lanes follow the address. Byte `i` of the transfer sits on lane `addr[1:0]+i` on the bus and at register byte `(reg_addr & ~3) + lane`. The register and memory addresses must therefore share their low two bits. When the effective address lands inside the unit's own register window, and outside the internal RAM window carved from it, the bus cycle still runs but no data moves. In that case an illegal-instruction interrupt accompanies the end-of-instruction pulse.

Top module: `ldst_xfer_unit`

## Requirements
- R1: After reset, `busy`, `done`, `illegal_irq` and `req_valid` are 0 and every register byte reads as zero.
- R2: The effective address equals `instr_w1` when bit 28 of `instr_w0` is 0. It equals `struct_base + instr_w1` (modulo 2^32) when bit 28 is 1. This address appears unchanged on `req_addr`.
- R3: The byte count is `instr_w0[26:24]`. With lane `L = addr[1:0]`, a count of 0 or a count greater than `4-L` is illegal. Such an instruction issues no bus request and ends with `done` and `illegal_irq` together.
- R4: The register address is `instr_w0[5:0]`. If its low two bits differ from the effective address's low two bits, the instruction is illegal and is handled as in R3.
- R5: For a legal instruction, `req_be` is the contiguous mask that starts at bit `L` and spans the byte count.
- R6: `instr_w0[29]` selects store (1) or load (0), and `instr_w0[27]` selects I/O space (1) or memory (0). `req_cmd` is 00 for a memory read, 01 for a memory write, 10 for an I/O read and 11 for an I/O write.
- R7: On a store outside the self window, each enabled lane `k` of `req_wdata` carries register byte `{reg_addr[5:2],k}`. Disabled lanes are zero.
- R8: On a load outside the self window, each enabled lane of `ack_rdata` is written to its register byte at the acknowledge. Every other register byte keeps its value.
- R9: If the effective address is inside [SELF_BASE, SELF_BASE+SELF_SIZE) and outside [RAM_BASE, RAM_BASE+RAM_SIZE), the bus cycle is still issued. A store drives all-zero write data, and a load writes no register. `illegal_irq` is raised with `done` in the cycle after the acknowledge.
- R10: `done` is high for exactly one cycle per instruction, in the cycle after the acknowledge or two cycles after `start` when R3 or R4 applies. `illegal_irq` is high only together with `done`.
- R11: `start` is ignored while `busy` is high, and the instruction in flight keeps its latched words. `busy` is 0 in the cycle after `done`.
- R12: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr`, `req_cmd`, `req_be` and `req_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction; sampled only while idle |
| instr_w0 | input | 32 | First instruction word (direction, space, relative flag, count, register address) |
| instr_w1 | input | 32 | Second instruction word (absolute address or offset) |
| struct_base | input | 32 | Data-structure base added in relative mode |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle end-of-instruction pulse |
| illegal_irq | output | 1 | Illegal-instruction interrupt, high with `done` |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus request accepted |
| req_addr | output | 32 | Bus byte address |
| req_cmd | output | 2 | Bus command (R6 encoding) |
| req_be | output | 4 | Byte enables |
| req_wdata | output | 32 | Write data, lane-aligned |
| ack | input | 1 | Bus completion |
| ack_rdata | input | 32 | Read data returned with `ack` |

## Verification
The acknowledge of a load and the self-window decision act in the same cycle. At that edge the register-file write must be suppressed and the fault path must be taken instead of normal completion. The bench provokes this collision with loads into the self window and into the RAM hole inside it, using registers that hold known non-zero bytes. It judges the outcome from `illegal_irq` at the `done` pulse and from later stores of the same registers. Those stores must return the earlier bytes unchanged after a self-window load, and the new bytes after a load into the RAM hole.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DECODE   = 3'd1,
    ST_BUS_REQ  = 3'd2,
    ST_WAIT_ACK = 3'd3,
    ST_COMPLETE = 3'd4,
    ST_FAULT    = 3'd5
  } ldst_state_e;

  // command = {io_space, is_write}
  typedef enum logic [1:0] {
    CMD_MEM_RD = 2'b00,
    CMD_MEM_WR = 2'b01,
    CMD_IO_RD  = 2'b10,
    CMD_IO_WR  = 2'b11
  } bus_cmd_e;

  localparam int DIR_BIT   = 29;
  localparam int REL_BIT   = 28;
  localparam int SPACE_BIT = 27;
  localparam int CNT_LSB   = 24;
  localparam int CNT_W     = 3;

  // contiguous mask starting at lane, spanning cnt bytes (clipped at lane 3)
  function automatic logic [3:0] lane_mask(input logic [1:0] lane, input logic [2:0] cnt);
    logic [3:0] m;
    m = '0;
    for (int i = 0; i < 4; i++) begin
      if (i >= int'(lane) && i < int'(lane) + int'(cnt)) m[i] = 1'b1;
    end
    return m;
  endfunction

  // legal count: at least one byte, never past the end of the 32-bit word
  function automatic logic count_ok(input logic [1:0] lane, input logic [2:0] cnt);
    return (cnt != 3'd0) && (int'(cnt) <= 4 - int'(lane));
  endfunction

  function automatic logic in_window(input logic [31:0] addr, input logic [31:0] base,
                                     input logic [31:0] size);
    logic [31:0] d;
    d = addr - base;
    return d < size;
  endfunction

  function automatic logic [31:0] expand_be(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
#(
  parameter int          RAW       = 6,
  parameter logic [31:0] SELF_BASE = 32'h4000_0000,
  parameter logic [31:0] SELF_SIZE = 32'h0000_1000,
  parameter logic [31:0] RAM_BASE  = 32'h4000_0800,
  parameter logic [31:0] RAM_SIZE  = 32'h0000_0400
) (
  input  logic [31:0]    w0,
  input  logic [31:0]    w1,
  input  logic [31:0]    base,
  output logic [31:0]    ea,
  output logic [3:0]     be,
  output logic [1:0]     cmd,
  output logic           is_store,
  output logic [RAW-1:0] reg_addr,
  output logic           illegal,
  output logic           self_hit
);

  logic             rel;
  logic             io;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       lane;
  logic             cnt_bad;
  logic             align_bad;

  always_comb begin
    is_store  = w0[DIR_BIT];
    rel       = w0[REL_BIT];
    io        = w0[SPACE_BIT];
    cnt       = w0[CNT_LSB +: CNT_W];
    reg_addr  = w0[RAW-1:0];
    ea        = rel ? (base + w1) : w1;
    lane      = ea[1:0];
    be        = lane_mask(lane, cnt);
    cnt_bad   = !count_ok(lane, cnt);
    align_bad = (reg_addr[1:0] != lane);
    illegal   = cnt_bad || align_bad;
    self_hit  = in_window(ea, SELF_BASE, SELF_SIZE) && !in_window(ea, RAM_BASE, RAM_SIZE);
    cmd       = {io, is_store};
  end

endmodule

// File: rtl/ldst_fsm.sv
module ldst_fsm
  import ldst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        illegal,
  input  logic        self_hit,
  input  logic        is_store,
  input  logic        req_ready,
  input  logic        ack,
  output ldst_state_e state,
  output logic        capture,
  output logic        req_valid,
  output logic        rf_we,
  output logic        done,
  output logic        irq,
  output logic        busy,
  output logic        ev_decode_fault
);

  ldst_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (start) nxt = ST_DECODE;
      ST_DECODE:   nxt = illegal ? ST_FAULT : ST_BUS_REQ;
      ST_BUS_REQ:  if (req_ready) nxt = ST_WAIT_ACK;
      ST_WAIT_ACK: if (ack) nxt = self_hit ? ST_FAULT : ST_COMPLETE;
      ST_COMPLETE: nxt = ST_IDLE;
      ST_FAULT:    nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign capture         = (state == ST_IDLE) && start;
  assign req_valid       = (state == ST_BUS_REQ);
  assign rf_we           = (state == ST_WAIT_ACK) && ack && !is_store && !self_hit;
  assign done            = (state == ST_COMPLETE) || (state == ST_FAULT);
  assign irq             = (state == ST_FAULT);
  assign busy            = (state != ST_IDLE);
  assign ev_decode_fault = (state == ST_DECODE) && illegal;

endmodule

// File: rtl/ldst_regfile.sv
module ldst_regfile #(
  parameter int NBYTES = 64,
  localparam int NWORDS = NBYTES / 4,
  localparam int WIW    = $clog2(NWORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [WIW-1:0] widx,
  input  logic           we,
  input  logic [3:0]     be,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata
);

  logic [NWORDS-1:0][3:0][7:0] mem;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < NWORDS; w++) mem[w][l] <= '0;
      end else if (we && be[l]) begin
        mem[widx][l] <= wdata[8*l +: 8];
      end
    end
  end

  assign rdata = mem[widx];

endmodule

// File: rtl/ldst_xfer_unit.sv
module ldst_xfer_unit
  import ldst_pkg::*;
#(
  parameter int          NBYTES    = 64,
  parameter logic [31:0] SELF_BASE = 32'h4000_0000,
  parameter logic [31:0] SELF_SIZE = 32'h0000_1000,
  parameter logic [31:0] RAM_BASE  = 32'h4000_0800,
  parameter logic [31:0] RAM_SIZE  = 32'h0000_0400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] instr_w0,
  input  logic [31:0] instr_w1,
  input  logic [31:0] struct_base,
  output logic        busy,
  output logic        done,
  output logic        illegal_irq,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [31:0] req_addr,
  output logic [1:0]  req_cmd,
  output logic [3:0]  req_be,
  output logic [31:0] req_wdata,
  input  logic        ack,
  input  logic [31:0] ack_rdata
);

  localparam int RAW = $clog2(NBYTES);

  logic [31:0]    lat_w0, lat_w1, lat_base;
  logic [31:0]    ea;
  logic [3:0]     be;
  logic [1:0]     cmd;
  logic           is_store;
  logic [RAW-1:0] reg_addr;
  logic           illegal;
  logic           self_hit;
  ldst_state_e    state;
  logic           capture;
  logic           rf_we;
  logic           ev_decode_fault;
  logic [31:0]    rf_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_w0   <= '0;
      lat_w1   <= '0;
      lat_base <= '0;
    end else if (capture) begin
      lat_w0   <= instr_w0;
      lat_w1   <= instr_w1;
      lat_base <= struct_base;
    end
  end

  ldst_decode #(
    .RAW(RAW), .SELF_BASE(SELF_BASE), .SELF_SIZE(SELF_SIZE),
    .RAM_BASE(RAM_BASE), .RAM_SIZE(RAM_SIZE)
  ) u_dec (
    .w0(lat_w0), .w1(lat_w1), .base(lat_base),
    .ea(ea), .be(be), .cmd(cmd), .is_store(is_store),
    .reg_addr(reg_addr), .illegal(illegal), .self_hit(self_hit)
  );

  ldst_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .illegal(illegal),
    .self_hit(self_hit), .is_store(is_store), .req_ready(req_ready), .ack(ack),
    .state(state), .capture(capture), .req_valid(req_valid), .rf_we(rf_we),
    .done(done), .irq(illegal_irq), .busy(busy), .ev_decode_fault(ev_decode_fault)
  );

  ldst_regfile #(.NBYTES(NBYTES)) u_rf (
    .clk(clk), .rst_n(rst_n), .widx(reg_addr[RAW-1:2]), .we(rf_we),
    .be(be), .wdata(ack_rdata), .rdata(rf_rdata)
  );

  assign req_addr  = ea;
  assign req_cmd   = cmd;
  assign req_be    = be;
  assign req_wdata = (is_store && !self_hit) ? (rf_rdata & expand_be(be)) : 32'h0;

endmodule

// File: rtl/ldst_xfer_chk.sv
module ldst_xfer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        illegal_irq,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic [1:0]  req_cmd,
  input logic [3:0]  req_be,
  input logic [31:0] req_wdata,
  input logic        ev_decode_fault,
  input logic        rf_we,
  input logic        self_hit,
  input logic [31:0] lat_w0,
  input logic [31:0] lat_w1
);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_cmd)
                                && $stable(req_be) && $stable(req_wdata));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_irq |-> done);

  // R3
  decode_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_decode_fault |=> illegal_irq && !req_valid);

  // R9
  self_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && self_hit));

  // R5
  be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_be != 4'h0);

  // R11
  hold_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> $stable(lat_w0) && $stable(lat_w1));

endmodule

bind ldst_xfer_unit ldst_xfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .illegal_irq(illegal_irq),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_cmd(req_cmd),
  .req_be(req_be), .req_wdata(req_wdata), .ev_decode_fault(ev_decode_fault),
  .rf_we(rf_we), .self_hit(self_hit), .lat_w0(lat_w0), .lat_w1(lat_w1)
);

// File: tb/ldst_xfer_unit_tb.sv
module ldst_xfer_unit_tb;

  localparam logic [31:0] SB = 32'h4000_0000, SS = 32'h0000_1000;
  localparam logic [31:0] RB = 32'h4000_0800, RS = 32'h0000_0400;

  logic clk = 0, rst_n = 0, start = 0, req_ready = 0, ack = 0;
  logic [31:0] instr_w0 = 0, instr_w1 = 0, struct_base = 0, ack_rdata = 0;
  logic busy, done, illegal_irq, req_valid;
  logic [31:0] req_addr, req_wdata;
  logic [1:0] req_cmd;
  logic [3:0] req_be;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] rf_m [64];

  always #4 clk = ~clk;

  ldst_xfer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr_w0(instr_w0), .instr_w1(instr_w1),
    .struct_base(struct_base), .busy(busy), .done(done), .illegal_irq(illegal_irq),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_cmd(req_cmd),
    .req_be(req_be), .req_wdata(req_wdata), .ack(ack), .ack_rdata(ack_rdata)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_mask(input int lane, input int cnt);
    logic [3:0] m = 0;
    for (int k = 0; k < 4; k++) m[k] = (k >= lane) && (k - lane < cnt);
    return m;
  endfunction

  function automatic logic [31:0] mk_w0(input bit st, input bit rel, input bit io,
                                        input int cnt, input int ra);
    return {2'b00, st, rel, io, 3'(cnt), 16'h0, 2'b00, 6'(ra)};
  endfunction

  // pokes start mid-flight when poke is set (R11)
  task automatic run(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] b,
                     input bit poke);
    bit st = w0[29], rel = w0[28], io = w0[27];
    int cnt = int'(w0[26:24]);
    int ra = int'(w0[5:0]);
    logic [31:0] ea = rel ? b + w1 : w1;
    int lane = int'(ea[1:0]);
    bit legal = (cnt >= 1) && (cnt <= 4 - lane) && (ra % 4 == lane);
    bit self = ((ea - SB) < SS) && !((ea - RB) < RS);
    logic [3:0] m = exp_mask(lane, cnt);
    logic [31:0] ew = 0, rd;
    for (int k = 0; k < 4; k++)
      if (m[k] && st && !self) ew[8*k +: 8] = rf_m[(ra & ~3) + k];
    @(negedge clk);
    instr_w0 = w0; instr_w1 = w1; struct_base = b; start = 1;
    @(negedge clk);
    start = 0; instr_w0 = 32'hFFFF_FFFF; instr_w1 = 32'h1234_5678; struct_base = 32'hDEAD_0000;
    @(negedge clk);
    if (!legal) begin
      chk(!req_valid, "R3/R4 no bus on illegal", 32'(req_valid), 0);
      chk(done && illegal_irq, "R3/R4 fault done+irq", {done, illegal_irq}, 2'b11);
      @(negedge clk);
      chk(!done && !busy, "R10 done single cycle", {done, busy}, 0);
      return;
    end
    chk(req_valid, "R3 legal issues request", 32'(req_valid), 1);
    chk(req_addr == ea, "R2 effective address", req_addr, ea);
    chk(req_cmd == {io, st}, "R6 command", 32'(req_cmd), 32'({io, st}));
    chk(req_be == m, "R5 byte enables", 32'(req_be), 32'(m));
    if (st) chk(req_wdata == ew, self ? "R9 self store zero data" : "R7 store data", req_wdata, ew);
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(req_valid && req_addr == ea, "R12 hold while not ready", req_addr, ea);
    end
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    chk(!req_valid && !done, "R12 request drops after accept", 32'(req_valid), 0);
    if (poke) begin
      start = 1; instr_w0 = mk_w0(0, 0, 0, 1, 0); instr_w1 = 32'h0;
      @(negedge clk);
      start = 0;
    end
    repeat ($urandom % 3) @(negedge clk);
    rd = $urandom;
    ack = 1; ack_rdata = rd;
    @(negedge clk);
    ack = 0;
    chk(done, "R10 done after ack", 32'(done), 1);
    chk(illegal_irq == self, "R9 irq on self window", 32'(illegal_irq), 32'(self));
    if (!st && !self)
      for (int k = 0; k < 4; k++) if (m[k]) rf_m[(ra & ~3) + k] = rd[8*k +: 8];
    @(negedge clk);
    chk(!done && !busy && !req_valid, poke ? "R11 start ignored while busy" : "R10 done single cycle",
        {done, busy, req_valid}, 0);
  endtask

  task automatic rand_instr();
    int lane = $urandom % 4;
    int region = $urandom % 4;
    int cnt = ($urandom % 5 == 0) ? int'($urandom % 8) : 1 + int'($urandom % (4 - lane));
    int ra = ($urandom % 6 == 0) ? int'($urandom % 64) : int'(($urandom % 16) * 4 + lane);
    bit rel = $urandom % 2;
    logic [31:0] ea, b;
    case (region)
      0, 1: ea = 32'h1000_0000 | (($urandom % 32'h10000) & ~32'h3);
      2:    ea = SB + (($urandom % SS) & ~32'h3);
      default: ea = RB + (($urandom % RS) & ~32'h3);
    endcase
    ea = ea | 32'(lane);
    b = rel ? $urandom : 32'h0;
    run(mk_w0($urandom % 2, rel, $urandom % 2, cnt, ra), rel ? ea - b : ea, b, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) rf_m[i] = 8'h0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !illegal_irq && !req_valid, "R1 reset outputs",
        {busy, done, illegal_irq, req_valid}, 0);
    rst_n = 1;
    run(mk_w0(1, 0, 0, 4, 8), 32'h1000_0100, 0, 0);            // R1 registers zero
    run(mk_w0(0, 0, 0, 4, 8), 32'h1000_0100, 0, 0);            // R8 load full word
    run(mk_w0(1, 0, 1, 4, 8), 32'h0000_0200, 0, 0);            // R6 io write, R7
    run(mk_w0(0, 1, 1, 2, 14), 32'hFFFF_FFF6, 32'h2000_0000, 0); // R2 negative offset
    run(mk_w0(1, 1, 0, 4, 12), 32'h10, 32'h1000_0000, 0);      // R7
    run(mk_w0(0, 0, 0, 0, 0), 32'h1000_0000, 0, 0);            // R3 zero count
    run(mk_w0(0, 0, 0, 4, 1), 32'h1000_0001, 0, 0);            // R3 over span
    run(mk_w0(0, 0, 0, 2, 3), 32'h1000_0003, 0, 0);            // R3 lane 3 two bytes
    run(mk_w0(0, 0, 0, 1, 3), 32'h1000_0003, 0, 0);            // R3 lane 3 one byte ok
    run(mk_w0(0, 0, 0, 1, 2), 32'h1000_0001, 0, 0);            // R4 misaligned
    run(mk_w0(0, 0, 0, 4, 8), SB + 32'h40, 0, 0);              // R9 self load no write
    run(mk_w0(1, 0, 0, 4, 8), 32'h1000_0100, 0, 0);            // R8 regs unchanged after self load
    run(mk_w0(1, 0, 0, 4, 8), SB + 32'h44, 0, 0);              // R9 self store zero data
    run(mk_w0(0, 0, 0, 4, 8), RB + 32'h10, 0, 0);              // R9 RAM hole excluded
    run(mk_w0(1, 0, 0, 4, 8), 32'h1000_0100, 0, 0);            // R8 RAM hole load wrote
    run(mk_w0(0, 0, 0, 3, 9), 32'h1000_0105, 0, 1);            // R11 poke while busy
    for (int i = 0; i < 400; i++) rand_instr();
    for (int w = 0; w < 16; w++) run(mk_w0(1, 0, 0, 4, w * 4), 32'h1000_0000, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule